// File: doc/BRIEF.md
# Single-Edge PWM Match Unit

This block turns a shared up-counter into three pulse-width-modulated outputs. A fourth compare value, the period register, sets the length of one cycle. When a tick arrives while the counter holds the period value, the counter goes back to zero and every PWM output that is high goes low. Each channel rises when the counter reaches that channel's own compare value. The duty cycle is therefore set by the gap between the channel compare value and the period value.

Each channel has a mode bit. With the mode bit set, the channel drives its PWM waveform. With it clear, the pin shows a fixed level held in a separate level register. The PWM state of a channel keeps running while the pin is in level mode, so switching back resumes the waveform already in progress.

Software accesses all settings through a small synchronous port. A write takes effect at the clock edge where `wr_en` is high. A read returns the addressed value combinationally.

Top module: `pwm_match_unit`

## Requirements
- R1: While reset is active, and at reset release, the following are all zero: the counter, the three compare registers, the period register, the mode register and the level register. All outputs are low.
- R2: The counter advances by one on each clock edge where `tick` is high. It keeps its value on every edge where `tick` is low.
- R3: On a tick where the counter equals the period register, the counter becomes zero. The counter reaches no other value on that edge.
- R4: A PWM-mode channel output becomes high on the edge where the counter moves to that channel's compare value, so it is high in the cycle the counter shows that value.
- R5: On a tick where the counter equals the period register, a PWM-mode output whose compare value is nonzero goes low.
- R6: A channel whose compare value is zero is set on the wrapping tick. The set wins over the clear, so the output is high while the counter shows zero.
- R7: A PWM-mode channel whose compare value is larger than the period register stays low for the whole cycle after the first wrap.
- R8: Mode bit i (bit i of address 4) selects the source of output i. A value of 1 selects the PWM waveform. A value of 0 selects bit i of the level register (address 5).
- R9: The address map is:
  - 0 to 2: the channel compare values
  - 3: the period value
  - 4: the mode bits, in bits [2:0]
  - 5: the level bits, in bits [2:0]
  - 6: the counter, read only
  
  Writes to address 6 or 7 have no effect, and address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` |
| pwm_out | output | 3 | Channel outputs |

## Verification
The timing properties assume that `wr_en` is low in the cycle they sample, because a write to a compare, mode or period register changes the very condition being checked. The stimulus never writes while `tick` is high. All configuration happens with the counter halted.

The bench also avoids lowering the period below the current count, which would otherwise let the counter run across its full range. When a smaller period is needed, it applies reset first.

// File: rtl/pwm_match_pkg.sv
package pwm_match_pkg;

  // Kind of register selected by an address, for an NCH-channel unit:
  // compare values first, then period, mode, level and the counter.
  typedef enum logic [2:0] {
    K_MATCH,
    K_PERIOD,
    K_MODE,
    K_LEVEL,
    K_COUNT,
    K_NONE
  } reg_kind_e;

  function automatic reg_kind_e reg_kind(input int unsigned a, input int unsigned nch);
    if (a < nch)             return K_MATCH;
    else if (a == nch)       return K_PERIOD;
    else if (a == nch + 1)   return K_MODE;
    else if (a == nch + 2)   return K_LEVEL;
    else if (a == nch + 3)   return K_COUNT;
    else                     return K_NONE;
  endfunction

endpackage

// File: rtl/pwm_reset_sync.sv
module pwm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_match_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int AW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [CW-1:0]     wdata,
  input  logic [CW-1:0]     count_val,
  output logic [NCH*CW-1:0] match_flat,
  output logic [CW-1:0]     period_val,
  output logic [NCH-1:0]    mode_val,
  output logic [NCH-1:0]    level_val,
  output logic [CW-1:0]     rd_data
);

  reg_kind_e kind;

  logic [CW-1:0]  match_q [NCH];
  logic [CW-1:0]  match_d [NCH];
  logic [CW-1:0]  period_q, period_d;
  logic [NCH-1:0] mode_q, mode_d;
  logic [NCH-1:0] level_q, level_d;

  assign kind = reg_kind(32'(addr), NCH);

  // next-state
  always_comb begin
    period_d = period_q;
    mode_d   = mode_q;
    level_d  = level_q;
    for (int i = 0; i < NCH; i++) begin
      match_d[i] = match_q[i];
      if (kind == K_MATCH && addr == AW'(i)) match_d[i] = wdata;
    end
    case (kind)
      K_PERIOD: period_d = wdata;
      K_MODE:   mode_d   = wdata[NCH-1:0];
      K_LEVEL:  level_d  = wdata[NCH-1:0];
      default:  ;
    endcase
  end

  // registers, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) match_q[i] <= '0;
      period_q <= '0;
      mode_q   <= '0;
      level_q  <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NCH; i++) match_q[i] <= match_d[i];
      period_q <= period_d;
      mode_q   <= mode_d;
      level_q  <= level_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (kind)
      K_MATCH: begin
        for (int i = 0; i < NCH; i++)
          if (addr == AW'(i)) rd_data = match_q[i];
      end
      K_PERIOD: rd_data = period_q;
      K_MODE:   rd_data = CW'(mode_q);
      K_LEVEL:  rd_data = CW'(level_q);
      K_COUNT:  rd_data = count_val;
      default:  rd_data = '0;
    endcase
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign match_flat[g*CW +: CW] = match_q[g];
  end

  assign period_val = period_q;
  assign mode_val   = mode_q;
  assign level_val  = level_q;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [CW-1:0] period_val,
  output logic [CW-1:0] count_val,
  output logic [CW-1:0] count_nxt,
  output logic          wrap
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  // value the counter takes if this cycle ticks
  always_comb begin
    wrap      = tick && (cnt_q == period_val);
    count_nxt = (cnt_q == period_val) ? '0 : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= count_nxt;
  end

  assign count_val = cnt_q;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wrap,
  input  logic [CW-1:0] count_nxt,
  input  logic [CW-1:0] match_val,
  input  logic          mode_pwm,
  input  logic          level,
  output logic          out
);

  logic pwm_q, pwm_d;
  logic hit;

  // set wins over the wrap clear
  always_comb begin
    hit   = (count_nxt == match_val);
    pwm_d = pwm_q;
    if (hit)       pwm_d = 1'b1;
    else if (wrap) pwm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pwm_q <= 1'b0;
    else if (tick) pwm_q <= pwm_d;
  end

  assign out = mode_pwm ? pwm_q : level;

endmodule

// File: rtl/pwm_match_unit.sv
module pwm_match_unit
  import pwm_match_pkg::*;
#(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int AW  = $clog2(NCH + 4)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [CW-1:0]  wdata,
  output logic [CW-1:0]  rd_data,
  output logic [NCH-1:0] pwm_out
);

  logic              rst_sync_n;
  logic [NCH*CW-1:0] match_flat;
  logic [CW-1:0]     period_val;
  logic [NCH-1:0]    mode_val;
  logic [NCH-1:0]    level_val;
  logic [CW-1:0]     count_val;
  logic [CW-1:0]     count_nxt;
  logic              wrap;

  pwm_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_regfile #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .count_val  (count_val),
    .match_flat (match_flat),
    .period_val (period_val),
    .mode_val   (mode_val),
    .level_val  (level_val),
    .rd_data    (rd_data)
  );

  pwm_timebase #(.CW(CW)) u_tb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick       (tick),
    .period_val (period_val),
    .count_val  (count_val),
    .count_nxt  (count_nxt),
    .wrap       (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .tick      (tick),
      .wrap      (wrap),
      .count_nxt (count_nxt),
      .match_val (match_flat[g*CW +: CW]),
      .mode_pwm  (mode_val[g]),
      .level     (level_val[g]),
      .out       (pwm_out[g])
    );
  end

endmodule

// File: rtl/pwm_match_unit_chk.sv
module pwm_match_unit_chk #(
  parameter int NCH = 3,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_en,
  input logic [CW-1:0]     count_val,
  input logic [CW-1:0]     period_val,
  input logic [NCH*CW-1:0] match_flat,
  input logic [NCH-1:0]    mode_val,
  input logic [NCH-1:0]    pwm_out
);

  localparam logic [CW-1:0] ONE = CW'(1);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (count_val == '0 && pwm_out == '0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(count_val)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (tick && count_val != period_val) |=> count_val == $past(count_val) + ONE); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (tick && count_val == period_val) |=> count_val == '0); // R3

  for (genvar g = 0; g < NCH; g++) begin : g_prop
    logic [CW-1:0] m;
    assign m = match_flat[g*CW +: CW];

    AST_SET_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n) (tick && !wr_en && mode_val[g] && count_val != period_val && (count_val + ONE) == m) |=> pwm_out[g]); // R4
    AST_CLEAR_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (tick && !wr_en && mode_val[g] && count_val == period_val && m != '0) |=> !pwm_out[g]); // R5
    AST_ZERO_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (tick && !wr_en && mode_val[g] && count_val == period_val && m == '0) |=> pwm_out[g]); // R6
    AST_BEYOND_LOW: assert property (@(posedge clk) disable iff (!rst_n) (tick && !wr_en && mode_val[g] && count_val == period_val && m > period_val) |=> !pwm_out[g]); // R7
  end

endmodule

bind pwm_match_unit pwm_match_unit_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick       (tick),
  .wr_en      (wr_en),
  .count_val  (count_val),
  .period_val (period_val),
  .match_flat (match_flat),
  .mode_val   (mode_val),
  .pwm_out    (pwm_out)
);

// File: tb/test_pwm_match_unit.sv
module test_pwm_match_unit;

  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam int AW  = 3;
  localparam logic [AW-1:0] A_COUNT = 3'd6;

  logic           clk;
  logic           rst_n;
  logic           tick;
  logic           wr_en;
  logic [AW-1:0]  addr;
  logic [CW-1:0]  wdata;
  logic [CW-1:0]  rd_data;
  logic [NCH-1:0] pwm_out;

  pwm_match_unit #(.NCH(NCH), .CW(CW), .AW(AW)) i_pwm_match_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rd_data (rd_data),
    .pwm_out (pwm_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  typedef struct {
    string          tag;
    logic [CW-1:0]  cnt;
    logic [NCH-1:0] out;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string cur_tag = "";

  // requirement-level model
  int unsigned    m_match [NCH];
  int unsigned    m_period;
  int unsigned    m_cnt;
  logic [NCH-1:0] m_mode, m_level, m_pq;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NCH-1:0] model_out();
    logic [NCH-1:0] r;
    for (int i = 0; i < NCH; i++) r[i] = m_mode[i] ? m_pq[i] : m_level[i];
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) m_match[i] = 0;
    m_period = 0; m_cnt = 0; m_mode = '0; m_level = '0; m_pq = '0;
  endtask

  task automatic model_tick();
    bit w;
    int unsigned nx;
    w  = (m_cnt == m_period);
    nx = w ? 0 : ((m_cnt + 1) & 32'hFFFF);
    for (int i = 0; i < NCH; i++) begin
      if (nx == m_match[i]) m_pq[i] = 1'b1;
      else if (w)           m_pq[i] = 1'b0;
    end
    m_cnt = nx;
  endtask

  // driver: one cycle, pushes the expectation for after the next edge
  task automatic step(input logic t);
    item_t it;
    @(negedge clk);
    tick = t; wr_en = 1'b0; addr = A_COUNT;
    if (t) model_tick();
    it.tag = cur_tag;
    it.cnt = m_cnt[CW-1:0];
    it.out = model_out();
    q.push_back(it);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    case (a)
      3'd0, 3'd1, 3'd2: m_match[a] = d;
      3'd3: m_period = d;
      3'd4: m_mode   = d[NCH-1:0];
      3'd5: m_level  = d[NCH-1:0];
      default: ;
    endcase
    @(negedge clk);
    wr_en = 1'b0; addr = A_COUNT;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [CW-1:0] exp);
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; addr = a;
    #1;
    check(tag, 32'(rd_data), 32'(exp));
    addr = A_COUNT;
  endtask

  task automatic chk_out(input string tag);
    @(negedge clk);
    tick = 1'b0;
    #1;
    check(tag, 32'(pwm_out), 32'(model_out()));
  endtask

  task automatic do_reset();
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: compare after each active edge
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      check({it.tag, " count"}, 32'(rd_data), 32'(it.cnt));
      check({it.tag, " out"}, 32'(pwm_out), 32'(it.out));
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b1; tick = 1'b0; wr_en = 1'b0; addr = A_COUNT; wdata = '0;
    model_reset();
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 7; a++) rd("R1 reset register", AW'(a), '0);
    chk_out("R1 reset outputs");

    // R9: configuration and read-back
    wr(3'd0, 16'd2);
    wr(3'd1, 16'd5);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd7);
    wr(3'd4, 16'h0007);
    rd("R9 match0", 3'd0, 16'd2);
    rd("R9 match1", 3'd1, 16'd5);
    rd("R9 match2", 3'd2, 16'd0);
    rd("R9 period", 3'd3, 16'd7);
    rd("R9 mode", 3'd4, 16'h0007);
    wr(3'd6, 16'h0055);
    wr(3'd7, 16'h00AA);
    rd("R9 count ignores write", 3'd6, '0);
    rd("R9 addr7 reads zero", 3'd7, '0);
    rd("R9 period unchanged", 3'd3, 16'd7);

    // R2 R3 R4 R5 R6: continuous ticks through several periods
    cur_tag = "R2/R3/R4/R5/R6 continuous";
    for (int i = 0; i < 20; i++) step(1'b1);

    // R2: sparse ticks, counter must hold between them
    cur_tag = "R2/R4/R5 alternate";
    for (int i = 0; i < 24; i++) step(i % 2 == 0);
    cur_tag = "R2 hold";
    for (int i = 0; i < 6; i++) step(1'b0);
    cur_tag = "R2/R3 two-of-three";
    for (int i = 0; i < 24; i++) step(i % 3 != 0);

    // R7: compare above period
    wr(3'd2, 16'd9);
    cur_tag = "R7 match beyond period";
    for (int i = 0; i < 20; i++) step(1'b1);

    // R8: level mode on channels 0 and 2
    wr(3'd5, 16'h0005);
    wr(3'd4, 16'h0002);
    rd("R9 level", 3'd5, 16'h0005);
    chk_out("R8 level mode");
    cur_tag = "R8 mixed modes";
    for (int i = 0; i < 12; i++) step(1'b1);
    wr(3'd5, 16'h0000);
    chk_out("R8 level cleared");
    wr(3'd4, 16'h0007);
    chk_out("R8 back to pwm resumes");
    cur_tag = "R8/R4 after mode switch";
    for (int i = 0; i < 10; i++) step(1'b1);

    // R6 R7 with zero period after fresh reset
    do_reset();
    rd("R1 count after re-reset", 3'd6, '0);
    chk_out("R1 outputs after re-reset");
    wr(3'd1, 16'd3);
    wr(3'd4, 16'h0007);
    cur_tag = "R3/R6/R7 zero period";
    for (int i = 0; i < 8; i++) step(1'b1);

    // R6 with period 4 and channel 0 compare 0
    wr(3'd3, 16'd4);
    wr(3'd2, 16'd2);
    cur_tag = "R6/R4/R5 period four";
    for (int i = 0; i < 15; i++) step(1'b1);

    @(negedge clk);
    @(negedge clk);
    summary();
  end

endmodule